// File: doc/BRIEF.md
# Four-Phase Instruction Fetch/Execute Sequencer

This block paces a small microcontroller core. It divides the incoming clock into four non-overlapping phases, Q1 to Q4. One full rotation of the four phases forms one instruction cycle. In every cycle it fetches the word at the program counter while it executes the word fetched in the cycle before. It owns the 12-bit program counter and the 14-bit instruction register. It drives the program-memory address. It also drives per-phase data-memory strobes and an execute-enable to the datapath.

The datapath raises a branch request with a target address during Q4 of the instruction that changes flow. The sequencer then loads the target into the program counter at the cycle boundary. It drops the word that was prefetched in sequence, and runs the next cycle as a forced no-operation. No strobe is issued in that cycle. A branch therefore costs two instruction cycles and every other instruction costs one.

Top module: `qphase_seq`

## Requirements
- R1: While `rst_n` is low, `phase` is 4'b0001 (Q1), `pm_addr` is 0, `ir_word` is the no-operation code 14'h0000, `cyc_count` is 0, and `exec_en`, `dm_rd` and `dm_wr` are low.
- R2: `phase` is one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It advances one bit per clock and wraps from Q4 to Q1. `clkout` is low in Q1 and Q2 and high in Q3 and Q4.
- R3: `pm_addr` stays constant within an instruction cycle. Without a taken branch it rises by one at each Q4-to-Q1 boundary, and it wraps from 12'hFFF to 12'h000.
- R4: At each Q4-to-Q1 boundary without a taken branch, `ir_word` captures the `pm_data` present in Q4. It holds that value for the whole next cycle.
- R5: In a cycle that executes, `exec_en` is high in all four phases, `dm_rd` is high only in Q2 and `dm_wr` is high only in Q4.
- R6: A `br_req` sampled in Q4 of a cycle that executes is taken. In the next cycle `pm_addr` equals the `br_target` sampled with it, and `ir_word` is 14'h0000. In that cycle `exec_en`, `dm_rd` and `dm_wr` stay low in every phase.
- R7: `br_req` has no effect when it is high outside Q4, or in Q4 of a flushed cycle. In both cases the address advances by one.
- R8: `cyc_count` rises by one at each Q4-to-Q1 boundary. A run of N instructions that contains one taken branch spans N+1 instruction cycles.
- R9: The first instruction cycle after reset is flushed, with no execute-enable and no strobes. The word at address 0 executes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four ticks per instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pm_addr | output | 12 | Program-memory address (program counter) |
| pm_data | input | 14 | Instruction word returned for `pm_addr` |
| br_req | input | 1 | Branch request from the executing instruction |
| br_target | input | 12 | Branch destination address |
| phase | output | 4 | One-hot phase, bit 0 = Q1 |
| clkout | output | 1 | Quarter-rate cycle marker, high in Q3/Q4 |
| ir_word | output | 14 | Instruction register contents |
| exec_en | output | 1 | Current cycle executes (not flushed) |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |
| cyc_count | output | 16 | Instruction cycles since reset |

## Verification
Two things happen at the same Q4-to-Q1 boundary: the sequential fetch of the prefetched word and the branch redirect. The bench sets up this collision by raising `br_req` in Q4 while a sequential word is on `pm_data`. It then checks that the address jumps to the target, and that the instruction register holds the no-operation code, not the fetched word. It also raises a second request in Q4 of the flushed cycle, and checks that the sequencer ignores it. Strobes are checked in every phase of the flushed cycle and of the cycle that follows it.

// File: rtl/qphase_pkg.sv
// Package: shared widths, phase encoding and the no-operation word for the
// four-phase sequencer. Assumes a 4K-word program space and 14-bit words.
package qphase_pkg;
    parameter int PC_W  = 12;
    parameter int IW_W  = 14;
    parameter int CYC_W = 16;
    parameter int NPH   = 4;
    localparam logic [IW_W-1:0] NOP_WORD = '0;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;
endpackage

// File: rtl/qphase_phase_gen.sv
// Phase generator: divides the input clock by four into Q1..Q4, exports a
// one-hot vector, the quarter-rate clock marker and an instruction cycle
// counter. Assumes a synchronous active-low reset that restarts at Q1.
module qphase_phase_gen
    import qphase_pkg::*;
#(
    parameter int CW = CYC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    output phase_e         ph,
    output logic [NPH-1:0] ph_onehot,
    output logic           ph_last,
    output logic           clk_q,
    output logic [CW-1:0]  cycles
);
    phase_e ph_r;

    // Rotate the phase one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_r <= PH_Q1;
        else        ph_r <= phase_e'(ph_r + 2'd1);
    end

    // Count completed instruction cycles at each Q4 boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)            cycles <= '0;
        else if (ph_r == PH_Q4) cycles <= cycles + 1'b1;
    end

    // Expand the phase index to one bit per phase.
    for (genvar g = 0; g < NPH; g++) begin : g_onehot
        assign ph_onehot[g] = (ph_r == phase_e'(g));
    end

    assign ph      = ph_r;
    assign ph_last = (ph_r == PH_Q4);
    assign clk_q   = ph_r[1];
endmodule

// File: rtl/qphase_pc_unit.sv
// Program counter: loads the branch target or increments at the Q4/Q1
// boundary, holding steady through the rest of the cycle. Wraps at 4K.
module qphase_pc_unit
    import qphase_pkg::*;
#(
    parameter int AW = PC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bound,
    input  logic          take,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);
    // Advance or redirect the counter once per instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= '0;
        else if (bound) pc <= take ? target : pc + 1'b1;
    end
endmodule

// File: rtl/qphase_ir_unit.sv
// Instruction register and flush flag: latches the fetched word at the
// cycle boundary or, when a branch is taken, substitutes a no-operation
// and marks the next cycle as flushed. Reset starts in a flushed cycle.
module qphase_ir_unit
    import qphase_pkg::*;
#(
    parameter int WW = IW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bound,
    input  logic          take,
    input  logic [WW-1:0] fetched,
    output logic [WW-1:0] ir,
    output logic          flushed
);
    // Capture the fetched word, or a forced no-operation after a branch.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir <= NOP_WORD[WW-1:0];
        else if (bound) ir <= take ? NOP_WORD[WW-1:0] : fetched;
    end

    // Mark whether the coming execute cycle is suppressed.
    always_ff @(posedge clk) begin
        if (!rst_n)     flushed <= 1'b1;
        else if (bound) flushed <= take;
    end
endmodule

// File: rtl/qphase_seq.sv
// Top: four-phase fetch/execute sequencer. Fetches at pm_addr while the
// instruction register executes; a branch request in Q4 of an executing
// cycle redirects the counter and flushes the following cycle.
module qphase_seq
    import qphase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [PC_W-1:0]  pm_addr,
    input  logic [IW_W-1:0]  pm_data,
    input  logic             br_req,
    input  logic [PC_W-1:0]  br_target,
    output logic [NPH-1:0]   phase,
    output logic             clkout,
    output logic [IW_W-1:0]  ir_word,
    output logic             exec_en,
    output logic             dm_rd,
    output logic             dm_wr,
    output logic [CYC_W-1:0] cyc_count
);
    phase_e ph;
    logic   at_q4;
    logic   flushed;
    logic   take;

    qphase_phase_gen #(.CW(CYC_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .ph(ph), .ph_onehot(phase),
        .ph_last(at_q4), .clk_q(clkout), .cycles(cyc_count)
    );

    qphase_pc_unit #(.AW(PC_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .bound(at_q4), .take(take),
        .target(br_target), .pc(pm_addr)
    );

    qphase_ir_unit #(.WW(IW_W)) u_ir (
        .clk(clk), .rst_n(rst_n), .bound(at_q4), .take(take),
        .fetched(pm_data), .ir(ir_word), .flushed(flushed)
    );

    // Decide branch acceptance and per-phase execute strobes.
    always_comb begin
        take    = at_q4 && br_req && !flushed;
        exec_en = !flushed;
        dm_rd   = !flushed && (ph == PH_Q2);
        dm_wr   = !flushed && (ph == PH_Q4);
    end
endmodule

// File: rtl/qphase_seq_chk.sv
// Checker: temporal properties of the sequencer's ports, bound to the top.
module qphase_seq_chk
    import qphase_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  pm_addr,
    input logic             br_req,
    input logic [PC_W-1:0]  br_target,
    input logic [NPH-1:0]   phase,
    input logic             exec_en,
    input logic             dm_rd,
    input logic             dm_wr,
    input logic [CYC_W-1:0] cyc_count
);
    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> phase == 4'b0001);
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[3] |=> phase == ($past(phase) << 1));
    p_wr_q4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |-> (phase[3] && exec_en));
    p_rd_q2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |-> (phase[1] && exec_en));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !phase[3] |=> $stable(pm_addr));
    p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !(br_req && exec_en)) |=> pm_addr == $past(pm_addr) + 1'b1);
    p_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && br_req && exec_en) |=> (pm_addr == $past(br_target) && !exec_en));
    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase[3] |=> cyc_count == $past(cyc_count) + 1'b1);
endmodule

bind qphase_seq qphase_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .br_req(br_req),
    .br_target(br_target), .phase(phase), .exec_en(exec_en),
    .dm_rd(dm_rd), .dm_wr(dm_wr), .cyc_count(cyc_count)
);

// File: tb/test_qphase_seq.sv
// Directed bench for the four-phase sequencer; one task per scenario.
module test_qphase_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pm_addr;
    logic [13:0] pm_data;
    logic        br_req = 1'b0;
    logic [11:0] br_target = '0;
    logic [3:0]  phase;
    logic        clkout;
    logic [13:0] ir_word;
    logic        exec_en, dm_rd, dm_wr;
    logic [15:0] cyc_count;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [13:0] word_at(logic [11:0] a);
        return {2'b10, a};
    endfunction
    assign pm_data = word_at(pm_addr);

    qphase_seq i_qphase_seq (
        .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_data(pm_data),
        .br_req(br_req), .br_target(br_target), .phase(phase),
        .clkout(clkout), .ir_word(ir_word), .exec_en(exec_en),
        .dm_rd(dm_rd), .dm_wr(dm_wr), .cyc_count(cyc_count)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_q(int q);
        while (phase !== (4'b0001 << q)) @(negedge clk);
    endtask

    // Check one full cycle's strobes; pm_addr and ir fixed for the cycle.
    task automatic check_cycle(string req, logic ex, logic [11:0] a, logic [13:0] w);
        wait_q(0);
        for (int q = 0; q < 4; q++) begin
            check({req, " phase"}, phase, 4'b0001 << q);
            check({req, " clkout"}, clkout, (q >= 2));
            check({req, " pm_addr"}, pm_addr, a);
            check({req, " ir_word"}, ir_word, w);
            check({req, " exec_en"}, exec_en, ex);
            check({req, " dm_rd"}, dm_rd, ex && (q == 1));
            check({req, " dm_wr"}, dm_wr, ex && (q == 3));
            @(negedge clk);
        end
    endtask

    task automatic branch_now(logic [11:0] t);
        wait_q(3);
        br_req = 1'b1;
        br_target = t;
        @(negedge clk);
        br_req = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 phase", phase, 4'b0001);
        check("R1 pm_addr", pm_addr, 0);
        check("R1 ir_word", ir_word, 0);
        check("R1 cyc_count", cyc_count, 0);
        check("R1 strobes", {exec_en, dm_rd, dm_wr}, 0);
        rst_n = 1'b1;
    endtask

    // R9 first cycle flushed, then R2/R4/R5 sequential flow.
    task automatic t_startup;
        check_cycle("R9", 1'b0, 12'd0, 14'h0);
        check_cycle("R4/R5 c1", 1'b1, 12'd1, word_at(12'd0));
        check_cycle("R3/R2 c2", 1'b1, 12'd2, word_at(12'd1));
    endtask

    // R6 branch collides with sequential fetch; R7 request in flushed Q4.
    task automatic t_branch;
        logic [11:0] a;
        wait_q(0);
        a = pm_addr;
        branch_now(12'h7F0);
        wait_q(3);
        br_req = 1'b1; br_target = 12'h123;  // R7 flushed-cycle request
        @(negedge clk);
        br_req = 1'b0;
        wait_q(0);
        check("R7 flushed ignored", pm_addr, 12'h7F1);
        check("R6 target word", ir_word, word_at(12'h7F0));
        check("R6 resume exec", exec_en, 1'b1);
        a = pm_addr;
        // Flushed-cycle strobes.
        branch_now(12'h040);
        check_cycle("R6 flushed", 1'b0, 12'h040, 14'h0);
        check_cycle("R6 after", 1'b1, 12'h041, word_at(12'h040));
    endtask

    // R7 request outside Q4 ignored.
    task automatic t_ignore;
        logic [11:0] a;
        wait_q(0);
        a = pm_addr;
        wait_q(1);
        br_req = 1'b1; br_target = 12'h555;
        @(negedge clk);
        br_req = 1'b0;
        wait_q(0);
        check("R7 off-Q4 ignored", pm_addr, a + 12'd1);
        check("R7 exec kept", exec_en, 1'b1);
    endtask

    // R3 wrap at top of address space.
    task automatic t_wrap;
        branch_now(12'hFFF);
        wait_q(0);
        @(negedge clk);
        wait_q(0);
        check("R3 wrap addr", pm_addr, 12'h000);
        check("R3 wrap ir", ir_word, word_at(12'hFFF));
    endtask

    // R8: five instructions, third branches; expect 6 cycles.
    task automatic t_count;
        logic [15:0] c0;
        logic [11:0] b;
        wait_q(0);
        b = pm_addr - 12'd1;  // address of instruction now executing (I0)
        c0 = cyc_count;
        wait_q(1); @(negedge clk);  // pass I0
        wait_q(0); @(negedge clk);  // I1
        wait_q(0);                  // I2 executing: branch
        branch_now(12'h300);
        wait_q(0); @(negedge clk);  // flushed
        wait_q(0); @(negedge clk);  // I3 at 0x300
        wait_q(0); @(negedge clk);  // I4 at 0x301
        wait_q(0);
        check("R8 next word", ir_word, word_at(12'h302));
        check("R8 cycles", cyc_count - c0, 16'd6);
        check("R8 base", b + 12'd1 != 12'h300, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_startup();
        t_branch();
        t_ignore();
        t_wrap();
        t_count();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule